// File: doc/BRIEF.md
# Two-Wire Serial Control Register Bank

This block is a slave on a two-wire serial bus (open-drain data, master-driven clock) that holds a small bank of control bytes for the rest of the chip. The bus lines are oversampled by the system clock. A transfer begins with a START and a 7-bit slave address plus a direction bit. In a write transfer the first byte after the address selects a register (the pointer), and every further byte is stored at the pointer, which then advances by one. A read transfer returns bytes from wherever the pointer was left by an earlier transfer, and advances it after each byte.

Addresses 00h through 14h exist. A pointer byte above 14h is refused with no acknowledge. Address 00h returns a fixed identification byte and 14h returns a live status input; both are read-only. A 12-bit clock divide ratio is formed from the byte at 01h (the upper eight bits) and the upper nibble of the byte at 02h. The byte at 01h is only a shadow copy. The divide ratio output changes only when 02h is written, and it then takes both bytes at once, so it never shows a half-updated value.

Top module: `twi_regbank`

## Requirements
- R1: The block acknowledges the address byte only when its upper seven bits equal the SLAVE_ADDR parameter (default 4Ch, so 98h writes and 99h reads). Any other address gets no acknowledge, and the rest of that transfer changes nothing.
- R2: In a write transfer the first byte is taken as the register pointer. Values 00h to 14h are acknowledged. A value above 14h gets no acknowledge, and the rest of the transfer until the next START is ignored.
- R3: Each data byte after the pointer is acknowledged and stored at the pointer, which then advances by one. The byte for writable address n appears on cfg_flat bits [8n+7:8n].
- R4: div_ratio equals {byte 01h, byte 02h bits 7:4}. It changes only on a write to 02h. A write to 01h alone leaves it unchanged.
- R5: After reset, div_ratio is 1693 (69Dh), byte 01h is 69h, byte 02h is D0h, every other stored byte is 00h, and SDA is released.
- R6: Address 00h reads as the CHIP_ID parameter (default 3Ah) and address 14h reads as status_i. Writes to these two addresses, and to addresses above 14h reached by advancing the pointer, are acknowledged and have no effect. Their cfg_flat positions read zero.
- R7: A read transfer returns bytes starting at the pointer left by the previous transfer, advancing after each byte. It continues while the master acknowledges and ends on a master no-acknowledge. Addresses above 14h read as 00h.
- R8: A START at any point, including in the middle of a byte, aborts the current transfer and restarts the address phase.
- R9: A STOP releases SDA and returns the block to idle.
- R10: The block changes its SDA drive only in the cycle after a detected SCL falling edge, START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When high, pulls SDA low |
| status_i | input | 8 | Live status byte returned at address 14h |
| div_ratio | output | 12 | Committed clock divide ratio |
| cfg_flat | output | 168 | Stored register bytes, byte n at bits [8n+7:8n] |

## Verification
The assertions check several rules on every cycle. The divide ratio stays still except in the cycle after a strobe to 02h, and a strobe to 01h never moves it. cfg_flat moves only after a write strobe to a writable address. A STOP always leaves SDA released, and the SDA drive changes only after an SCL fall, START or STOP. The bench scenarios cover what needs a whole bus transfer to observe. These are the acknowledge or refusal of slave addresses and pointer bytes, the pointer carrying over from a write transfer into a later read, reads of the identification and status bytes, and recovery after a START arrives in the middle of a byte.

// File: rtl/twi_bank_pkg.sv
package twi_bank_pkg;
  localparam int          REG_COUNT    = 21;
  localparam logic [7:0]  LAST_ADDR    = 8'h14;
  localparam logic [7:0]  DIV_MSB_ADDR = 8'h01;
  localparam logic [7:0]  DIV_LSB_ADDR = 8'h02;
  localparam int          FLAT_W       = 8 * REG_COUNT;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK, ST_WR, ST_RD, ST_RACK
  } bus_state_t;

  function automatic logic addr_in_range(input logic [7:0] a);
    return a <= LAST_ADDR;
  endfunction

  function automatic logic is_read_only(input logic [7:0] a);
    return (a == 8'h00) || (a == LAST_ADDR);
  endfunction

  function automatic logic [7:0] reg_default(input logic [7:0] a);
    if (a == DIV_MSB_ADDR) return 8'h69;
    if (a == DIV_LSB_ADDR) return 8'hD0;
    return 8'h00;
  endfunction

  function automatic logic [11:0] join_div(input logic [7:0] msb, input logic [7:0] lsb);
    return {msb, lsb[7:4]};
  endfunction

  function automatic logic [7:0] next_ptr(input logic [7:0] p);
    return (p == 8'hFF) ? p : p + 8'd1;
  endfunction
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_s, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
  import twi_bank_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h4C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       wr_stb,
  output logic [7:0] wr_data,
  output logic [7:0] ptr
);
  bus_state_t state;
  logic [3:0] bit_cnt;
  logic [7:0] shreg, tx;
  logic       is_read, have_ptr, nack;
  logic       byte_done;

  assign byte_done = scl_fall && (bit_cnt == 4'd8);
  assign wr_stb    = (state == ST_WR) && byte_done && have_ptr;
  assign wr_data   = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      tx       <= '0;
      is_read  <= 1'b0;
      have_ptr <= 1'b0;
      nack     <= 1'b0;
      sda_oe   <= 1'b0;
      ptr      <= '0;
    end else if (stop_evt) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (start_evt) begin
      state    <= ST_ADDR;
      bit_cnt  <= '0;
      have_ptr <= 1'b0;
      sda_oe   <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (scl_rise) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_done) begin
            bit_cnt <= '0;
            if (shreg[7:1] == SLAVE_ADDR) begin
              is_read <= shreg[0];
              sda_oe  <= 1'b1;
              state   <= ST_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (is_read) begin
              tx     <= rd_data;
              sda_oe <= ~rd_data[7];
              state  <= ST_RD;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_WR;
            end
          end
        end
        ST_WR: begin
          if (scl_rise) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_done) begin
            bit_cnt <= '0;
            if (!have_ptr) begin
              if (addr_in_range(shreg)) begin
                ptr      <= shreg;
                have_ptr <= 1'b1;
                sda_oe   <= 1'b1;
                state    <= ST_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              ptr    <= next_ptr(ptr);
              sda_oe <= 1'b1;
              state  <= ST_ACK;
            end
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              ptr     <= next_ptr(ptr);
              state   <= ST_RACK;
            end else begin
              tx      <= {tx[6:0], 1'b0};
              sda_oe  <= ~tx[6];
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            nack <= sda_s;
          end else if (scl_fall) begin
            if (nack) begin
              state <= ST_IDLE;
            end else begin
              tx     <= rd_data;
              sda_oe <= ~rd_data[7];
              state  <= ST_RD;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/twi_reg_store.sv
module twi_reg_store
  import twi_bank_pkg::*;
#(
  parameter logic [7:0] CHIP_ID = 8'h3A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [7:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        rd_addr,
  input  logic [7:0]        status_i,
  output logic [7:0]        rd_data,
  output logic [11:0]       div_ratio,
  output logic [FLAT_W-1:0] cfg_flat
);
  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    localparam logic [7:0] ADDR = 8'(g);
    if (is_read_only(ADDR)) begin : g_ro
      assign cfg_flat[8*g +: 8] = 8'h00;
    end else begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          q <= reg_default(ADDR);
        else if (wr_stb && wr_addr == ADDR)  q <= wr_data;
      end
      assign cfg_flat[8*g +: 8] = q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      div_ratio <= join_div(reg_default(DIV_MSB_ADDR), reg_default(DIV_LSB_ADDR));
    else if (wr_stb && wr_addr == DIV_LSB_ADDR)
      div_ratio <= join_div(cfg_flat[8*DIV_MSB_ADDR +: 8], wr_data);
  end

  logic [4:0] rd_idx;
  assign rd_idx = rd_addr[4:0];

  always_comb begin
    if (!addr_in_range(rd_addr))   rd_data = 8'h00;
    else if (rd_addr == 8'h00)     rd_data = CHIP_ID;
    else if (rd_addr == LAST_ADDR) rd_data = status_i;
    else                           rd_data = cfg_flat[8*rd_idx +: 8];
  end
endmodule

// File: rtl/twi_regbank.sv
module twi_regbank
  import twi_bank_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h4C,
  parameter logic [7:0] CHIP_ID     = 8'h3A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [7:0]        status_i,
  output logic [11:0]       div_ratio,
  output logic [FLAT_W-1:0] cfg_flat
);
  logic       sda_s, scl_rise_evt, scl_fall_evt, start_evt, stop_evt;
  logic       wr_stb;
  logic [7:0] wr_data, wr_addr, rd_data;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise_evt), .scl_fall(scl_fall_evt),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  twi_slave_fsm #(.SLAVE_ADDR(SLAVE_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise_evt), .scl_fall(scl_fall_evt),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .rd_data(rd_data), .sda_oe(sda_oe),
    .wr_stb(wr_stb), .wr_data(wr_data), .ptr(wr_addr)
  );

  twi_reg_store #(.CHIP_ID(CHIP_ID)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(wr_addr), .status_i(status_i),
    .rd_data(rd_data), .div_ratio(div_ratio), .cfg_flat(cfg_flat)
  );
endmodule

// File: rtl/twi_regbank_chk.sv
module twi_regbank_chk
  import twi_bank_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic [11:0]       div_ratio,
  input logic [FLAT_W-1:0] cfg_flat,
  input logic              wr_stb,
  input logic [7:0]        wr_addr,
  input logic              scl_fall_evt,
  input logic              start_evt,
  input logic              stop_evt
);
  a_r4_ratio_moves_only_on_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && wr_addr == DIV_LSB_ADDR) |=> $stable(div_ratio));

  a_r4_msb_alone_holds_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr == DIV_MSB_ADDR) |=> $stable(div_ratio));

  a_r6_protected_writes_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb || wr_addr == 8'h00 || wr_addr >= LAST_ADDR) |=> $stable(cfg_flat));

  a_r9_stop_releases_sda: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  a_r10_drive_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> $past(scl_fall_evt || start_evt || stop_evt));
endmodule

bind twi_regbank twi_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .div_ratio(div_ratio),
  .cfg_flat(cfg_flat), .wr_stb(wr_stb), .wr_addr(wr_addr),
  .scl_fall_evt(scl_fall_evt), .start_evt(start_evt), .stop_evt(stop_evt)
);

// File: tb/tb_twi_regbank.sv
module tb_twi_regbank;
  localparam int         CLK_PERIOD = 10;
  localparam int         QCYC       = 6;
  localparam logic [7:0] WADDR      = 8'h98;
  localparam logic [7:0] RADDR      = 8'h99;
  localparam logic [7:0] ID_BYTE    = 8'h3A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic [7:0] status_i = 8'h00;
  logic [11:0] div_ratio;
  logic [167:0] cfg_flat;
  int n_tests = 0;
  int n_fail = 0;
  logic done = 1'b0;

  assign sda_bus = sda_m & ~sda_oe;
  always #(CLK_PERIOD/2) clk = ~clk;

  twi_regbank dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .status_i(status_i), .div_ratio(div_ratio), .cfg_flat(cfg_flat)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cfg(input int n);
    return cfg_flat[8*n +: 8];
  endfunction

  task automatic wait_q();
    repeat (QCYC) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(); scl = 1'b1; wait_q();
    sda_m = 1'b0; wait_q(); scl = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(); scl = 1'b1; wait_q();
    sda_m = 1'b1; wait_q(); wait_q();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wait_q(); scl = 1'b1; wait_q(); wait_q(); scl = 1'b0; wait_q();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wait_q(); scl = 1'b1; wait_q(); b = sda_bus;
    wait_q(); scl = 1'b0; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(input logic master_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) get_bit(b[i]);
    put_bit(~master_ack);
  endtask

  task automatic write_one(input logic [7:0] p, input logic [7:0] d, input string req);
    logic a;
    bus_start();
    send_byte(WADDR, a); chk({req, " address ack"}, a, 1);
    send_byte(p, a);     chk({req, " pointer ack"}, a, 1);
    send_byte(d, a);     chk({req, " data ack"}, a, 1);
    bus_stop();
  endtask

  task automatic read_at(input logic [7:0] p, output logic [7:0] b);
    logic a;
    bus_start();
    send_byte(WADDR, a);
    send_byte(p, a);
    bus_start();
    send_byte(RADDR, a);
    recv_byte(1'b0, b);
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R5 div_ratio default", div_ratio, 12'd1693);
    chk("R5 byte 01h default", cfg(1), 8'h69);
    chk("R5 byte 02h default", cfg(2), 8'hD0);
    chk("R5 byte 03h default", cfg(3), 8'h00);
    chk("R5 sda released", sda_oe, 1'b0);
  endtask

  task automatic t_write_burst();
    logic a;
    bus_start();
    send_byte(WADDR, a); chk("R3 address ack", a, 1);
    send_byte(8'h03, a); chk("R3 pointer ack", a, 1);
    send_byte(8'hA5, a); chk("R3 data0 ack", a, 1);
    send_byte(8'h5A, a); chk("R3 data1 ack", a, 1);
    send_byte(8'hC3, a); chk("R3 data2 ack", a, 1);
    bus_stop();
    chk("R3 byte 03h", cfg(3), 8'hA5);
    chk("R3 byte 04h", cfg(4), 8'h5A);
    chk("R3 byte 05h", cfg(5), 8'hC3);
    chk("R9 sda released after stop", sda_oe, 1'b0);
  endtask

  task automatic t_bad_slave();
    logic a;
    logic [167:0] snap;
    snap = cfg_flat;
    bus_start();
    send_byte(8'h9A, a); chk("R1 foreign address refused", a, 0);
    send_byte(8'h03, a); chk("R1 no ack after refusal", a, 0);
    send_byte(8'hFF, a);
    bus_stop();
    chk("R1 registers untouched", (cfg_flat == snap), 1);
  endtask

  task automatic t_bad_ptr();
    logic a;
    logic [167:0] snap;
    snap = cfg_flat;
    bus_start();
    send_byte(WADDR, a); chk("R2 address ack", a, 1);
    send_byte(8'h15, a); chk("R2 pointer 15h refused", a, 0);
    send_byte(8'h33, a); chk("R2 data after refusal ignored", a, 0);
    bus_stop();
    chk("R2 registers untouched", (cfg_flat == snap), 1);
    bus_start();
    send_byte(WADDR, a);
    send_byte(8'h14, a); chk("R2 pointer 14h accepted", a, 1);
    bus_stop();
  endtask

  task automatic t_divider();
    write_one(8'h01, 8'h12, "R4 msb");
    chk("R4 msb alone keeps ratio", div_ratio, 12'h69D);
    chk("R4 msb shadow stored", cfg(1), 8'h12);
    write_one(8'h02, 8'h34, "R4 lsb");
    chk("R4 ratio committed on lsb", div_ratio, 12'h123);
    chk("R4 lsb stored", cfg(2), 8'h34);
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte(WADDR, a);
    send_byte(8'h03, a);
    bus_start();
    send_byte(RADDR, a); chk("R7 read address ack", a, 1);
    recv_byte(1'b1, b);  chk("R7 R10 read byte 03h", b, 8'hA5);
    recv_byte(1'b0, b);  chk("R7 R10 read byte 04h", b, 8'h5A);
    bus_stop();
    chk("R9 sda released after read", sda_oe, 1'b0);
    bus_start();
    send_byte(RADDR, a);
    recv_byte(1'b0, b);  chk("R7 pointer kept across transfers", b, 8'hC3);
    bus_stop();
    read_at(8'h01, b);   chk("R7 read shadow 01h", b, 8'h12);
  endtask

  task automatic t_read_only();
    logic a;
    logic [7:0] b;
    read_at(8'h00, b); chk("R6 identification byte", b, ID_BYTE);
    status_i = 8'h5E;
    read_at(8'h14, b); chk("R6 status byte", b, 8'h5E);
    write_one(8'h00, 8'hFF, "R6 ro write");
    read_at(8'h00, b); chk("R6 id after write", b, ID_BYTE);
    bus_start();
    send_byte(WADDR, a);
    send_byte(8'h13, a);
    send_byte(8'h44, a); chk("R6 write 13h ack", a, 1);
    send_byte(8'h55, a); chk("R6 write 14h acked", a, 1);
    send_byte(8'h66, a); chk("R6 write past 14h acked", a, 1);
    bus_stop();
    chk("R6 byte 13h stored", cfg(19), 8'h44);
    chk("R6 position 14h zero", cfg(20), 8'h00);
    bus_start();
    send_byte(WADDR, a);
    send_byte(8'h14, a);
    bus_start();
    send_byte(RADDR, a);
    recv_byte(1'b1, b); chk("R6 status unchanged by write", b, 8'h5E);
    recv_byte(1'b0, b); chk("R7 past 14h reads zero", b, 8'h00);
    bus_stop();
  endtask

  task automatic t_restart();
    logic a;
    logic [167:0] snap;
    snap = cfg_flat;
    bus_start();
    send_byte(WADDR, a);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
    bus_start();
    send_byte(WADDR, a); chk("R8 address ack after restart", a, 1);
    send_byte(8'h07, a); chk("R8 pointer ack after restart", a, 1);
    send_byte(8'h77, a); chk("R8 data ack after restart", a, 1);
    bus_stop();
    snap[8*7 +: 8] = 8'h77;
    chk("R8 only byte 07h changed", (cfg_flat == snap), 1);
    bus_start();
    send_byte(WADDR, a);
    send_byte(8'h08, a);
    put_bit(1'b1); put_bit(1'b0);
    bus_stop();
    chk("R9 idle after mid-byte stop", sda_oe, 1'b0);
    write_one(8'h08, 8'h88, "R9 after stop");
    chk("R9 write after mid-byte stop", cfg(8), 8'h88);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R9 watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write_burst();
    t_bad_slave();
    t_bad_ptr();
    t_divider();
    t_read();
    t_read_only();
    t_restart();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule